// File: doc/BRIEF.md
# Oversampled UART Receive Engine

This block takes an asynchronous serial line and turns each frame into a parallel byte on the system clock. A frame is one low start bit, eight data bits sent least significant bit first, no parity bit and one high stop bit. The line first passes through a two-stage synchronizer. An internal divider produces a one-cycle oversample enable at OVS times the bit rate. By default this is 16x, and 4x is the smallest ratio the design supports. The start-bit hunt, the sampling of each bit near its middle and the three-sample majority vote all advance on that enable. No derived clock is used.

A captured byte appears on `data_o` and raises `ready_o`. The flag stays high until the consumer pulses `ack_i` on the same clock. If the stop bit is low, the byte is dropped and `ferr_o` pulses for one cycle. The receiver then waits for the line to go high again before it hunts for the next start bit. A low pulse that has ended before the middle of the start bit is treated as noise.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `ready_o` and `ferr_o` are 0, `data_o` is 0 and the synchronizer holds the idle level 1.
- R2: A frame with a start bit of 0, eight data bits (bit 0 first) and a stop bit of 1 loads the eight data bits into `data_o`. `data_o` changes only when a valid frame completes.
- R3: `ready_o` rises after a valid frame completes and stays high until `ack_i` is sampled high. It is then low in the following cycle.
- R4: If a frame completes in the same cycle that `ack_i` is high, `ready_o` stays set and `data_o` takes the new byte.
- R5: A frame that completes while `ready_o` is still set replaces `data_o`, and `ready_o` stays high.
- R6: A low pulse on the line that has ended before the start bit's middle samples (7 to 9 of 16) returns the receiver to idle. It produces no byte and no `ferr_o` pulse.
- R7: Each bit is decided by a majority of three samples taken at oversample phases OVS/2-1, OVS/2 and OVS/2+1. A glitch shorter than one oversample period does not change the bit.
- R8: If the stop bit votes 0, `ready_o` and `data_o` are left unchanged and `ferr_o` pulses high for exactly one cycle.
- R9: After a framing error, the receiver does not hunt for a start bit until the line is back at 1. A line held low therefore gives one `ferr_o` pulse only.
- R10: The oversample enable is a one-cycle pulse every CLK_HZ/(BAUD*OVS) system clocks. Each bit lasts OVS enables.
- R11: The line reaches the receiver only through two flip-flops. A start bit is accepted only if `rx_i` was low two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| ack_i | input | 1 | Consumer acknowledge, one-cycle pulse that clears ready |
| data_o | output | DW | Last byte received |
| ready_o | output | 1 | A byte is waiting to be read |
| ferr_o | output | 1 | One-cycle pulse when a stop bit is missing |

## Verification
Two events can fall in the same cycle: a frame completing and the consumer's acknowledge. The bench holds `ack_i` high for a whole frame and the idle time after it, so the acknowledge is sure to coincide with the completion cycle. It then counts the cycles in which `ready_o` was high. Exactly one such cycle, with `data_o` carrying the new byte, shows that completion won over the acknowledge. Zero cycles would show that the acknowledge wiped out the new byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV = 325
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      q_o  <= 1'b1;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OVS = 16,
  localparam int PW = $clog2(OVS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] phase_i,
  input  logic          line_i,
  output logic          bit_o
);
  localparam int MID = OVS / 2;

  logic [2:0] smp_q;
  logic       in_win;

  assign in_win = (phase_i == PW'(MID - 1)) || (phase_i == PW'(MID)) ||
                  (phase_i == PW'(MID + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               smp_q <= 3'b111;
    else if (tick_i && in_win) smp_q <= {smp_q[1:0], line_i};
  end

  assign bit_o = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600,
  parameter int OVS    = 16,
  parameter int DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          ack_i,
  output logic [DW-1:0] data_o,
  output logic          ready_o,
  output logic          ferr_o
);
  localparam int DIV = CLK_HZ / (BAUD * OVS);
  localparam int PW  = $clog2(OVS);
  localparam int BW  = $clog2(DW);

  rx_state_e     state_q, state_d;
  logic [PW-1:0] phase_q, phase_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [DW-1:0] data_q;
  logic          ready_q, ferr_q;
  logic          tick, rx_s, vote, last_ph;
  logic          done, ferr_set, start_hit;

  uart_rx_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  uart_rx_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_vote #(.OVS(OVS)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .phase_i(phase_q),
    .line_i (rx_s),
    .bit_o  (vote)
  );

  assign last_ph   = tick && (phase_q == PW'(OVS - 1));
  assign start_hit = (state_q == ST_IDLE) && tick && !rx_s;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    shreg_d  = shreg_q;
    done     = 1'b0;
    ferr_set = 1'b0;
    if (tick && state_q != ST_IDLE && state_q != ST_HOLD)
      phase_d = last_ph ? '0 : phase_q + 1'b1;
    unique case (state_q)
      ST_IDLE: if (start_hit) begin
        state_d = ST_START;
        phase_d = '0;
      end
      ST_START: if (last_ph) begin
        // false start: line back high at mid-bit
        if (vote) state_d = ST_IDLE;
        else begin
          state_d = ST_DATA;
          bit_d   = '0;
        end
      end
      ST_DATA: if (last_ph) begin
        shreg_d = {vote, shreg_q[DW-1:1]};
        if (bit_q == BW'(DW - 1)) state_d = ST_STOP;
        else                      bit_d   = bit_q + 1'b1;
      end
      ST_STOP: if (last_ph) begin
        if (vote) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ferr_set = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: if (tick && rx_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      if (done) data_q <= shreg_q;
      ready_q <= done | (ready_q & ~ack_i);
      ferr_q  <= ferr_set;
    end
  end

  assign data_o  = data_q;
  assign ready_o = ready_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DW  = 8,
  parameter int DIV = 325
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_i,
  input logic          ack_i,
  input logic [DW-1:0] data_o,
  input logic          ready_o,
  input logic          ferr_o,
  input logic          tick_i,
  input logic          start_i,
  input logic          done_i
);
  localparam int GW = $clog2(DIV + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && seen_q |-> gap_q == GW'(DIV - 1));
  p_sync_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> $past(rx_i, 2) == 1'b0);
  p_ready_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !ack_i |=> ready_o);
  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && ack_i && !done_i |=> !ready_o);
  p_done_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);
  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o));
  p_ferr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |=> !ferr_o);
  p_ferr_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> !done_i && !$rose(ready_o));
endmodule

bind uart_rx_core uart_rx_chk #(.DW(DW), .DIV(DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rx_i   (rx_i),
  .ack_i  (ack_i),
  .data_o (data_o),
  .ready_o(ready_o),
  .ferr_o (ferr_o),
  .tick_i (tick),
  .start_i(start_hit),
  .done_i (done)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 781_250;
  localparam int OVS    = 16;
  localparam int BIT    = (CLK_HZ / (BAUD * OVS)) * OVS;

  typedef struct packed {
    logic [7:0] b;
    logic       stop_ok;
    logic       glitch;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h55, 1'b1, 1'b0}, '{8'hA3, 1'b1, 1'b0}, '{8'h00, 1'b1, 1'b0},
    '{8'hFF, 1'b1, 1'b0}, '{8'h81, 1'b1, 1'b1}, '{8'h3C, 1'b1, 1'b1},
    '{8'hC5, 1'b0, 1'b0}, '{8'h7E, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       ack = 1'b0;
  logic [7:0] data;
  logic       ready, ferr;

  int errors = 0;
  int checks = 0;
  int ferr_cnt = 0;
  int ferr_long = 0;
  int rdy_cnt = 0;
  logic ferr_prev = 1'b0;

  always #10 clk = ~clk;

  uart_rx_core #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS), .DW(8)) u_uart_rx_core (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rx_i   (rx),
    .ack_i  (ack),
    .data_o (data),
    .ready_o(ready),
    .ferr_o (ferr)
  );

  always @(negedge clk) begin
    if (ferr) ferr_cnt <= ferr_cnt + 1;
    if (ferr && ferr_prev) ferr_long <= ferr_long + 1;
    if (ready) rdy_cnt <= rdy_cnt + 1;
    ferr_prev <= ferr;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input logic gl);
    rx = v;
    if (gl) begin
      wait_cyc(BIT / 2);
      rx = ~v;
      wait_cyc(2);
      rx = v;
      wait_cyc(BIT - BIT / 2 - 2);
    end else begin
      wait_cyc(BIT);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input logic gl);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i], gl);
    send_bit(stop, 1'b0);
    rx = 1'b1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    wait_cyc(1);
    ack = 1'b0;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] last_good;
    int f0, r0;
    wait_cyc(3);
    // R1 reset state
    check("R1 ready", int'(ready), 0);
    check("R1 data", int'(data), 0);
    check("R1 ferr", int'(ferr), 0);
    rst_n = 1'b1;
    wait_cyc(2 * BIT);
    check("R1 idle line no byte", int'(ready), 0);
    last_good = 8'h00;

    // table walk
    for (int k = 0; k < 8; k++) begin
      f0 = ferr_cnt;
      send_frame(VECS[k].b, VECS[k].stop_ok, VECS[k].glitch);
      wait_cyc(BIT);
      if (VECS[k].stop_ok) begin
        check("R2 R10 R11 data", int'(data), int'(VECS[k].b));
        if (VECS[k].glitch) check("R7 glitch vote", int'(data), int'(VECS[k].b));
        check("R3 ready set", int'(ready), 1);
        wait_cyc(5);
        check("R3 ready held", int'(ready), 1);
        pulse_ack();
        check("R3 ready cleared", int'(ready), 0);
        last_good = VECS[k].b;
      end else begin
        check("R8 no ready", int'(ready), 0);
        check("R8 data kept", int'(data), int'(last_good));
        check("R8 ferr pulses", ferr_cnt - f0, 1);
        check("R8 ferr width", ferr_long, 0);
      end
    end

    // R6 false start
    f0 = ferr_cnt;
    rx = 1'b0;
    wait_cyc(BIT / 4);
    rx = 1'b1;
    wait_cyc(2 * BIT);
    check("R6 no ready", int'(ready), 0);
    check("R6 no ferr", ferr_cnt - f0, 0);
    send_frame(8'h96, 1'b1, 1'b0);
    wait_cyc(BIT);
    check("R6 recovers data", int'(data), 8'h96);
    pulse_ack();

    // R5 overwrite without ack
    send_frame(8'h12, 1'b1, 1'b0);
    wait_cyc(BIT);
    check("R5 first data", int'(data), 8'h12);
    send_frame(8'h34, 1'b1, 1'b0);
    wait_cyc(BIT);
    check("R5 ready kept", int'(ready), 1);
    check("R5 data replaced", int'(data), 8'h34);
    pulse_ack();
    check("R3 ready cleared after R5", int'(ready), 0);

    // R4 completion coincides with ack
    r0 = rdy_cnt;
    ack = 1'b1;
    send_frame(8'h9A, 1'b1, 1'b0);
    wait_cyc(BIT);
    ack = 1'b0;
    check("R4 ready one cycle", rdy_cnt - r0, 1);
    check("R4 data updated", int'(data), 8'h9A);

    // R9 break after framing error
    f0 = ferr_cnt;
    send_frame(8'h00, 1'b0, 1'b0);
    rx = 1'b0;
    wait_cyc(4 * BIT);
    check("R9 single ferr while low", ferr_cnt - f0, 1);
    rx = 1'b1;
    wait_cyc(2 * BIT);
    check("R9 no ready", int'(ready), 0);
    check("R9 data kept", int'(data), 8'h9A);
    send_frame(8'h5A, 1'b1, 1'b0);
    wait_cyc(BIT);
    check("R9 resumes", int'(data), 8'h5A);
    check("R9 ready", int'(ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule